// File: doc/BRIEF.md
# I2C Multi-Master Bus Monitor

This block listens to the clock and data wires of an I2C bus that several masters share. It synchronizes both wires to the system clock and finds START conditions (data falling while the clock is high) and STOP conditions (data rising while the clock is high). From the most recent of these two events it keeps two sticky flags and derives whether the bus is free, so that a local master knows when it may take the bus.

A local master that drives the data wire reports its intended level and its current phase. Whenever the master releases the wire (intends a high level) in a phase where it drives, and the sampled clock is high, the monitor expects a high data level. A low level there means another master won the bus, and a sticky collision flag is set until software clears it with a one-cycle clear pulse.

The monitor generates no bus traffic. It also raises a one-cycle interrupt pulse when a STOP ends a busy period and the interrupt is enabled.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, start_seen, stop_seen, stop_irq and collision are 0 and bus_free is 1.
- R2: With enable high, a falling SDA while SCL is high (a START) sets start_seen, clears stop_seen and drops bus_free; the flags change no later than the third rising clock edge after the pin change, because each wire passes two synchronizer stages.
- R3: With enable high, a rising SDA while SCL is high (a STOP) sets stop_seen, clears start_seen and raises bus_free; the two flags are never both set.
- R4: SDA changes while SCL is low are data, not conditions, and leave start_seen and stop_seen unchanged.
- R5: While enable is low, start_seen and stop_seen are held at 0, and conditions seen on the bus do not set them.
- R6: stop_irq is a single-cycle pulse raised when a STOP is detected while the bus is busy (start_seen set), enable is high and irq_en is high; no pulse when irq_en is low or when the bus was already free.
- R7: collision is set when enable is high, drive_phase is a driving phase (1 start, 2 repeated start, 3 address, 4 data, 5 acknowledge), drive_level is 1, and the synchronized SCL is high while the synchronized SDA is low.
- R8: No collision is flagged when drive_level is 0, when drive_phase is a non-driving code (0 idle, 6 receive, 7 reserved), or while SCL is low.
- R9: collision stays set until a coll_clr pulse; when a new mismatch and coll_clr occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitor enable; low clears the condition flags |
| irq_en | input | 1 | Enables the STOP interrupt pulse |
| scl_in | input | 1 | Asynchronous SCL level from the bus |
| sda_in | input | 1 | Asynchronous SDA level from the bus |
| drive_phase | input | 3 | Phase of the local master (codes as in R7, R8) |
| drive_level | input | 1 | SDA level the local master intends (1 = released) |
| coll_clr | input | 1 | Write-one-to-clear pulse for the collision flag |
| start_seen | output | 1 | Sticky: last condition seen was a START |
| stop_seen | output | 1 | Sticky: last condition seen was a STOP |
| bus_free | output | 1 | Bus may be claimed |
| stop_irq | output | 1 | One-cycle pulse on STOP ending a busy period |
| collision | output | 1 | Sticky lost-arbitration flag |

## Verification
The two functions that can meet in one cycle are the setting of the collision flag by a fresh mismatch and its clearing by software. The bench holds a mismatch on the bus (master releasing SDA in a driving phase, SCL high, SDA pulled low) and pulses coll_clr while it persists; the flag must remain 1, and only a clear pulse issued after SCL has gone low may return it to 0. The STOP interrupt is likewise judged against the flag state of the same STOP, counting pulses only when the bus was busy before it.

// File: rtl/i2cmon_pkg.sv
// Package: shared phase codes and helpers for the I2C bus monitor.
// Assumes: the local master reports its phase with a 3-bit code.
package i2cmon_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_RSTART = 3'd2,
        PH_ADDR   = 3'd3,
        PH_DATA   = 3'd4,
        PH_ACK    = 3'd5,
        PH_RECV   = 3'd6,
        PH_RSVD   = 3'd7
    } phase_e;

    // True for every phase in which the local master drives SDA.
    function automatic logic phase_drives(input logic [2:0] ph);
        case (ph)
            PH_START, PH_RSTART, PH_ADDR, PH_DATA, PH_ACK: phase_drives = 1'b1;
            default:                                       phase_drives = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous wires.
// Assumes: each bit is independent; reset value is the idle bus level.
module i2cmon_sync #(
    parameter int          WIDTH  = 2,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: pass the value one stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_cond_detect.sv
// Module: finds START and STOP conditions on synchronized SCL/SDA.
// Assumes: inputs are already synchronous; outputs are single-cycle
// combinational strobes valid in the cycle the SDA edge is seen.
module i2cmon_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det
);

    logic scl_d;
    logic sda_d;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // A condition needs SCL high before and after the SDA edge.
    always_comb begin
        start_det = scl_d & scl_s &  sda_d & ~sda_s;
        stop_det  = scl_d & scl_s & ~sda_d &  sda_s;
    end

endmodule

// File: rtl/i2cmon_bus_state.sv
// Module: tracks bus ownership from the latest START or STOP, and
// raises a STOP interrupt when a busy period ends.
// Assumes: start_det and stop_det are never high in the same cycle.
module i2cmon_bus_state (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic irq_en,
    input  logic start_det,
    input  logic stop_det,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic stop_irq
);

    logic busy;

    // Busy means the last event was a START.
    always_comb begin
        busy     = start_seen;
        bus_free = stop_seen | ~start_seen;
    end

    // Condition flags: latest event wins; disable clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else if (start_det) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end else if (stop_det) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end
    end

    // Interrupt pulse: STOP while busy with the interrupt enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_irq <= 1'b0;
        else        stop_irq <= enable & irq_en & stop_det & busy;
    end

    AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det) |=> (start_seen && !stop_seen)); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_seen, stop_seen}) <= 1); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_seen && !stop_seen)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq); // R6
    AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> (stop_seen && $past(start_seen))); // R6

endmodule

// File: rtl/i2cmon_arb_check.sv
// Module: lost-arbitration detector with a sticky flag.
// Assumes: drive_level and drive_phase are synchronous and held
// steady while the matching bus levels pass the synchronizer.
module i2cmon_arb_check
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic [2:0] drive_phase,
    input  logic       drive_level,
    input  logic       coll_clr,
    output logic       collision
);

    logic mismatch;

    // Released SDA must read high while SCL is high in a driving phase.
    always_comb begin
        mismatch = enable & phase_drives(drive_phase) & drive_level & scl_s & ~sda_s;
    end

    // Sticky flag: a new mismatch takes priority over the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        collision <= 1'b0;
        else if (mismatch) collision <= 1'b1;
        else if (coll_clr) collision <= 1'b0;
    end

    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> collision); // R7
    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && !coll_clr) |=> collision); // R9
    AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_clr && !mismatch) |=> !collision); // R9

endmodule

// File: rtl/i2c_bus_monitor.sv
// Module: top of the I2C multi-master bus monitor.
// Assumes: scl_in/sda_in are raw bus levels; all other inputs are
// synchronous to clk. Reset is synchronous and active low.
module i2c_bus_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       irq_en,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] drive_phase,
    input  logic       drive_level,
    input  logic       coll_clr,
    output logic       start_seen,
    output logic       stop_seen,
    output logic       bus_free,
    output logic       stop_irq,
    output logic       collision
);

    localparam int BUS_W = 2;

    logic [BUS_W-1:0] bus_s;
    logic             scl_s;
    logic             sda_s;
    logic             start_det;
    logic             stop_det;

    i2cmon_sync #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({BUS_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_in, sda_in}),
        .q_sync  (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2cmon_cond_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cmon_bus_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .irq_en     (irq_en),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free),
        .stop_irq   (stop_irq)
    );

    i2cmon_arb_check u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .drive_phase (drive_phase),
        .drive_level (drive_level),
        .coll_clr    (coll_clr),
        .collision   (collision)
    );

    AST_NO_DATA_AS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_s) |=> ($stable(start_seen) || !enable || !$past(enable))); // R4

endmodule

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       irq_en = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [2:0] drive_phase = 3'd0;
    logic       drive_level = 1'b0;
    logic       coll_clr = 1'b0;
    logic       start_seen, stop_seen, bus_free, stop_irq, collision;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
        .scl_in(scl_in), .sda_in(sda_in), .drive_phase(drive_phase),
        .drive_level(drive_level), .coll_clr(coll_clr),
        .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
        .stop_irq(stop_irq), .collision(collision)
    );

    // Count interrupt pulses away from the active edge.
    always @(negedge clk) if (stop_irq) irq_cnt++;

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Change one bus wire, then allow sync + register latency.
    task automatic set_scl(input logic v); scl_in = v; wait_cyc(4); endtask
    task automatic set_sda(input logic v); sda_in = v; wait_cyc(4); endtask

    task automatic t_reset;
        rst_n = 1'b0; enable = 1'b1; wait_cyc(3);
        rst_n = 1'b1; @(negedge clk);
        check(start_seen, 0, "R1 start_seen");
        check(stop_seen, 0, "R1 stop_seen");
        check(bus_free, 1, "R1 bus_free");
        check(collision, 0, "R1 collision");
        check(stop_irq, 0, "R1 stop_irq");
    endtask

    task automatic t_start_stop;
        sda_in = 1'b0; wait_cyc(3);          // three edges after change
        check(start_seen, 1, "R2 start latency");
        check(stop_seen, 0, "R2 stop cleared");
        check(bus_free, 0, "R2 bus busy");
        wait_cyc(1);
        set_sda(1'b1);
        check(stop_seen, 1, "R3 stop_seen");
        check(start_seen, 0, "R3 start cleared");
        check(bus_free, 1, "R3 bus free");
    endtask

    task automatic t_data_change;
        set_sda(1'b0);                       // START
        set_scl(1'b0);
        set_sda(1'b1);                       // data toggles, SCL low
        set_sda(1'b0);
        check(start_seen, 1, "R4 start kept");
        check(stop_seen, 0, "R4 no stop");
        set_sda(1'b1);
        set_scl(1'b1);
        check(start_seen, 1, "R4 still busy");
        set_sda(1'b0); set_sda(1'b1);        // repeated START, then STOP
        check(stop_seen, 1, "R3 stop after rs");
    endtask

    task automatic t_disable;
        set_sda(1'b0);                       // START
        enable = 1'b0; wait_cyc(2);
        check(start_seen, 0, "R5 disable clears");
        set_sda(1'b1);                       // STOP while disabled
        set_sda(1'b0);                       // START while disabled
        check(start_seen, 0, "R5 start ignored");
        check(stop_seen, 0, "R5 stop ignored");
        set_sda(1'b1);
        enable = 1'b1; wait_cyc(2);
    endtask

    task automatic t_irq;
        int base;
        irq_en = 1'b1;
        base = irq_cnt;
        set_sda(1'b0); set_sda(1'b1);
        check(irq_cnt - base, 1, "R6 one pulse on busy stop");
        base = irq_cnt;
        set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1); // STOP, bus free
        check(irq_cnt - base, 0, "R6 no pulse when free");
        irq_en = 1'b0;
        base = irq_cnt;
        set_sda(1'b0); set_sda(1'b1);
        check(irq_cnt - base, 0, "R6 no pulse irq_en low");
        check(stop_seen, 1, "R6 stop still seen");
    endtask

    // Set up a pulled-low SDA with SCL high and the master releasing.
    task automatic t_collision;
        for (int ph = 1; ph <= 5; ph++) begin
            set_scl(1'b0); set_sda(1'b0);
            drive_phase = 3'(ph); drive_level = 1'b1; wait_cyc(3);
            check(collision, 0, "R8 scl low no collision");
            set_scl(1'b1);
            check(collision, 1, $sformatf("R7 collision phase %0d", ph));
            coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0; wait_cyc(1);
            check(collision, 1, "R9 set wins over clear");
            set_scl(1'b0);
            coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0; wait_cyc(1);
            check(collision, 0, "R9 clear pulse");
            set_sda(1'b1); set_scl(1'b1);
        end
    endtask

    task automatic t_no_collision;
        int codes [3] = '{0, 6, 7};
        set_scl(1'b0); set_sda(1'b0);
        foreach (codes[i]) begin
            drive_phase = 3'(codes[i]); drive_level = 1'b1;
            set_scl(1'b1);
            check(collision, 0, $sformatf("R8 non-driving phase %0d", codes[i]));
            set_scl(1'b0);
        end
        drive_phase = 3'd4; drive_level = 1'b0;
        set_scl(1'b1);
        check(collision, 0, "R8 driving low");
        wait_cyc(5);
        check(collision, 0, "R9 stays clear");
        set_scl(1'b0); drive_phase = 3'd0;
        set_sda(1'b1); set_scl(1'b1);
    endtask

    initial begin
        t_reset;
        t_start_stop;
        t_data_change;
        t_disable;
        t_irq;
        t_collision;
        t_no_collision;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule